// File: doc/BRIEF.md
# Lightweight Feistel Cipher Loop Core

This block is an iterative block cipher engine for small devices. It works on a 96-bit block, seen as two 48-bit branches of six 8-bit words. It runs 93 Feistel rounds at one round per clock. A start pulse takes a full plaintext (or ciphertext) and a 96-bit key from parallel ports. A mode input chosen at that moment selects encryption or decryption. A one-cycle done flag then marks the moment the 96-bit result appears on the output.

The key is never stored in expanded form. A second Feistel network runs beside the data rounds and produces each round key in the cycle it is used. It has its own adders and substitution logic. Its counter-driven constant rises from 1 to 46, the two key halves trade places once, and the constant then falls back to 1. Because of this, the round keys form a palindrome. The same key input therefore serves both directions.

A small state machine sequences the work. It has three states. ST_IDLE waits. ST_RUN performs one round per cycle. ST_DONE shows the result flag. The transitions are:
- ST_IDLE to ST_RUN on start.
- ST_RUN to ST_RUN while rounds remain.
- ST_RUN to ST_DONE after the final round.
- ST_DONE to ST_RUN on a new start.
- ST_DONE to ST_IDLE otherwise.

Top module: `lwf_cipher_core`

## Requirements
- R1: After reset, and while reset is low, `done` is 0 and `text_out` is all zeros.
- R2: A start sampled while no operation runs loads the inputs. `done` is high exactly in the cycle that follows the 93rd clock edge after the loading edge, and is high for one cycle only.
- R3: The encryption round works on branches L = bits 95:48 and R = bits 47:0, with word i at bits 8i+7:8i of a branch. The new L is the old R. The new R is W(L) XOR F(R, K). F does the following, in order:
  - It adds the key word to each word modulo 256, with no carry between words.
  - It substitutes each bit position j of each word triplet (3t, 3t+1, 3t+2). The 3-bit value {w3t+2[j], w3t+1[j], w3t[j]} passes through the table 0,5,6,7,4,3,1,2.
  - It rotates word 3t right by one bit, leaves word 3t+1 as it is, and rotates word 3t+2 left by one bit.
  W moves word i to slot i+1 and the last word to slot 0. The result is final R concatenated with final L.
- R4: The round keys come from a key Feistel network on KL = key bits 95:48 and KR = key bits 47:0:
  - Each step sets new KL = KR and new KR = KL XOR W(F(KR, C)). C is zero except its lowest word, which holds the step constant.
  - Steps 1..46 use constant = step number. After step 46 the halves swap. Steps 47..92 use constant 93 - step.
  - Rounds 1..46 take KR before the step of that round. Round 47 takes the pre-swap KR of step 46. Rounds 48..93 take KL.
- R5: In decryption mode the new R is W⁻¹(L XOR F(R, K)), with the same round keys. Decrypting an encryption result under the same key returns the original block.
- R6: `text_out` changes only on the edge that completes an operation. It holds its value in every other cycle, including throughout a later operation.
- R7: A start during ST_RUN has no effect. The input data, key and mode are sampled only on the loading edge, so changes to them during a run leave the result and the timing unchanged.
- R8: A start in the ST_DONE cycle is accepted. `done` is still high in that cycle, and the new operation completes 93 edges after its loading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the current inputs |
| decrypt | input | 1 | 1 selects decryption, 0 selects encryption; sampled with start |
| text_in | input | 96 | Plaintext or ciphertext block |
| key_in | input | 96 | Cipher key |
| text_out | output | 96 | Result of the last completed operation |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
A new start can coincide with the ST_DONE cycle. In that cycle the flag for the finished result is still high while the next block is being loaded. The bench provokes this by chaining operations: it raises start in the very half-cycle where it observes `done`. It then judges the outcome in three ways: the finished result must still be readable in that cycle, `done` must fall in the next cycle, and the chained result must match the reference after exactly 93 further edges. A second collision, a start that lands in the middle of a run together with a changed mode, is judged by requiring an unchanged result and unchanged timing.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

    localparam int LWF_BLK    = 96;
    localparam int LWF_WB     = 8;
    localparam int LWF_ROUNDS = 93;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } lwf_state_e;

    // 3-bit substitution used bit-sliced across word triplets
    function automatic logic [2:0] sbox3(input logic [2:0] v);
        logic [2:0] o;
        case (v)
            3'd0: o = 3'd0;
            3'd1: o = 3'd5;
            3'd2: o = 3'd6;
            3'd3: o = 3'd7;
            3'd4: o = 3'd4;
            3'd5: o = 3'd3;
            3'd6: o = 3'd1;
            default: o = 3'd2;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/lwf_mix.sv
// Branch function: per-word add, bit-sliced substitution, bit rotation
module lwf_mix #(
    parameter int HALF = 48,
    parameter int WB   = 8
) (
    input  logic [HALF-1:0] x_in,
    input  logic [HALF-1:0] k_in,
    output logic [HALF-1:0] f_out
);
    import lwf_pkg::*;

    localparam int NW = HALF / WB;
    localparam int NT = NW / 3;

    logic [HALF-1:0] sum;

    genvar w, t, j;
    generate
        for (w = 0; w < NW; w++) begin : g_add
            assign sum[w*WB +: WB] = x_in[w*WB +: WB] + k_in[w*WB +: WB];
        end

        for (t = 0; t < NT; t++) begin : g_tri
            logic [WB-1:0] s0, s1, s2;
            for (j = 0; j < WB; j++) begin : g_bit
                logic [2:0] so;
                assign so = sbox3({sum[(3*t+2)*WB + j],
                                   sum[(3*t+1)*WB + j],
                                   sum[(3*t)*WB + j]});
                assign s0[j] = so[0];
                assign s1[j] = so[1];
                assign s2[j] = so[2];
            end
            assign f_out[(3*t)*WB   +: WB] = {s0[0], s0[WB-1:1]};
            assign f_out[(3*t+1)*WB +: WB] = s1;
            assign f_out[(3*t+2)*WB +: WB] = {s2[WB-2:0], s2[WB-1]};
        end
    endgenerate

endmodule

// File: rtl/lwf_data_round.sv
// One data Feistel round, forward or inverse word rotation by mode
module lwf_data_round #(
    parameter int HALF = 48,
    parameter int WB   = 8
) (
    input  logic [HALF-1:0] l_in,
    input  logic [HALF-1:0] r_in,
    input  logic [HALF-1:0] rkey,
    input  logic            dec,
    output logic [HALF-1:0] l_out,
    output logic [HALF-1:0] r_out
);
    logic [HALF-1:0] f;
    logic [HALF-1:0] mixed;

    lwf_mix #(.HALF(HALF), .WB(WB)) u_mix (
        .x_in  (r_in),
        .k_in  (rkey),
        .f_out (f)
    );

    assign mixed = l_in ^ f;

    always_comb begin
        l_out = r_in;
        if (dec)
            r_out = {mixed[WB-1:0], mixed[HALF-1:WB]};
        else
            r_out = {l_in[HALF-WB-1:0], l_in[HALF-1:HALF-WB]} ^ f;
    end

endmodule

// File: rtl/lwf_key_round.sv
// One key-schedule Feistel step with counter constant in the low word
module lwf_key_round #(
    parameter int HALF = 48,
    parameter int WB   = 8,
    parameter int CW   = 7
) (
    input  logic [HALF-1:0] kl_in,
    input  logic [HALF-1:0] kr_in,
    input  logic [CW-1:0]   kconst,
    output logic [HALF-1:0] kl_out,
    output logic [HALF-1:0] kr_out
);
    logic [HALF-1:0] cvec;
    logic [HALF-1:0] g;

    assign cvec = {{(HALF-CW){1'b0}}, kconst};

    lwf_mix #(.HALF(HALF), .WB(WB)) u_mix (
        .x_in  (kr_in),
        .k_in  (cvec),
        .f_out (g)
    );

    assign kl_out = kr_in;
    assign kr_out = kl_in ^ {g[HALF-WB-1:0], g[HALF-1:HALF-WB]};

endmodule

// File: rtl/lwf_ctrl.sv
// Sequencer: round counter, key constant, swap and key-select strobes
module lwf_ctrl #(
    parameter int ROUNDS = 93,
    parameter int CW     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic          last,
    output logic          key_step,
    output logic          swap_keys,
    output logic          use_kl,
    output logic [CW-1:0] kconst,
    output logic          done
);
    import lwf_pkg::*;

    localparam int HALF_K = ROUNDS / 2;
    localparam logic [CW-1:0] LAST_RND = CW'(ROUNDS);
    localparam logic [CW-1:0] MID_RND  = CW'(HALF_K);

    lwf_state_e    state, state_nxt;
    logic [CW-1:0] rnd, rnd_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rnd   <= '0;
        end else begin
            state <= state_nxt;
            rnd   <= rnd_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        rnd_nxt   = rnd;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_RUN;
                    rnd_nxt   = CW'(1);
                end
            end
            ST_RUN: begin
                if (rnd == LAST_RND)
                    state_nxt = ST_DONE;
                else
                    rnd_nxt = rnd + CW'(1);
            end
            ST_DONE: begin
                if (start) begin
                    state_nxt = ST_RUN;
                    rnd_nxt   = CW'(1);
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load      = start && (state != ST_RUN);
        step      = (state == ST_RUN);
        last      = step && (rnd == LAST_RND);
        key_step  = step && (rnd < LAST_RND);
        swap_keys = step && (rnd == MID_RND);
        use_kl    = (rnd > MID_RND);
        kconst    = (rnd <= MID_RND) ? rnd : (LAST_RND - rnd);
        done      = (state == ST_DONE);
    end

endmodule

// File: rtl/lwf_cipher_core.sv
module lwf_cipher_core
    import lwf_pkg::*;
#(
    parameter int BLK    = LWF_BLK,
    parameter int WB     = LWF_WB,
    parameter int ROUNDS = LWF_ROUNDS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           decrypt,
    input  logic [BLK-1:0] text_in,
    input  logic [BLK-1:0] key_in,
    output logic [BLK-1:0] text_out,
    output logic           done
);
    localparam int HALF = BLK / 2;
    localparam int CW   = $clog2(ROUNDS + 1);

    logic            load, step, last, key_step, swap_keys, use_kl;
    logic [CW-1:0]   kconst;
    logic [HALF-1:0] l_q, r_q, kl_q, kr_q;
    logic            dec_q;
    logic [HALF-1:0] rkey, l_nxt, r_nxt, kl_nxt, kr_nxt;

    lwf_ctrl #(.ROUNDS(ROUNDS), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .step      (step),
        .last      (last),
        .key_step  (key_step),
        .swap_keys (swap_keys),
        .use_kl    (use_kl),
        .kconst    (kconst),
        .done      (done)
    );

    assign rkey = use_kl ? kl_q : kr_q;

    lwf_data_round #(.HALF(HALF), .WB(WB)) u_data (
        .l_in  (l_q),
        .r_in  (r_q),
        .rkey  (rkey),
        .dec   (dec_q),
        .l_out (l_nxt),
        .r_out (r_nxt)
    );

    lwf_key_round #(.HALF(HALF), .WB(WB), .CW(CW)) u_key (
        .kl_in  (kl_q),
        .kr_in  (kr_q),
        .kconst (kconst),
        .kl_out (kl_nxt),
        .kr_out (kr_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q      <= '0;
            r_q      <= '0;
            kl_q     <= '0;
            kr_q     <= '0;
            dec_q    <= 1'b0;
            text_out <= '0;
        end else begin
            if (load) begin
                l_q   <= text_in[BLK-1:HALF];
                r_q   <= text_in[HALF-1:0];
                kl_q  <= key_in[BLK-1:HALF];
                kr_q  <= key_in[HALF-1:0];
                dec_q <= decrypt;
            end else if (step) begin
                l_q <= l_nxt;
                r_q <= r_nxt;
                if (key_step) begin
                    if (swap_keys) begin
                        kl_q <= kr_nxt;
                        kr_q <= kl_nxt;
                    end else begin
                        kl_q <= kl_nxt;
                        kr_q <= kr_nxt;
                    end
                end
            end
            if (last)
                text_out <= {r_nxt, l_nxt};
        end
    end

endmodule

// File: rtl/lwf_cipher_core_chk.sv
module lwf_cipher_core_chk #(
    parameter int ROUNDS = 93,
    parameter int BLK    = 96
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           done,
    input logic [BLK-1:0] text_out
);
    logic busy;
    int   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= 0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= 0;
        end else if (busy) begin
            cnt <= cnt + 1;
            if (cnt == ROUNDS - 1)
                busy <= 1'b0;
        end
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!done && text_out == '0));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == ROUNDS));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(text_out));

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

endmodule

bind lwf_cipher_core lwf_cipher_core_chk #(.ROUNDS(ROUNDS), .BLK(BLK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .text_out (text_out)
);

// File: tb/sim_lwf_cipher_core.sv
module sim_lwf_cipher_core;

    localparam int NR = 93;
    localparam int HK = NR / 2;
    localparam int NV = 4;

    // {plaintext, key}
    localparam logic [191:0] VEC [NV] = '{
        {96'h0, 96'h0},
        {96'hffffffffffffffffffffffff, 96'h0123456789abcdef01234567},
        {96'h0123456789abcdef01234567, 96'hfedcba9876543210fedcba98},
        {96'h800000000000000000000001, 96'hffffffffffffffffffffffff}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [95:0] text_in = '0;
    logic [95:0] key_in = '0;
    logic [95:0] text_out;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    lwf_cipher_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .decrypt  (decrypt),
        .text_in  (text_in),
        .key_in   (key_in),
        .text_out (text_out),
        .done     (done)
    );

    // ---------------- reference model ----------------
    function automatic logic [2:0] m_sb(input logic [2:0] v);
        case (v)
            3'd0: return 3'd0; 3'd1: return 3'd5; 3'd2: return 3'd6; 3'd3: return 3'd7;
            3'd4: return 3'd4; 3'd5: return 3'd3; 3'd6: return 3'd1; default: return 3'd2;
        endcase
    endfunction

    function automatic logic [47:0] m_f(input logic [47:0] x, input logic [47:0] k);
        logic [7:0] s [6];
        logic [7:0] o [6];
        logic [2:0] q;
        logic [47:0] y;
        for (int w = 0; w < 6; w++) s[w] = x[8*w +: 8] + k[8*w +: 8];
        for (int t = 0; t < 2; t++)
            for (int j = 0; j < 8; j++) begin
                q = m_sb({s[3*t+2][j], s[3*t+1][j], s[3*t][j]});
                o[3*t][j]   = q[0];
                o[3*t+1][j] = q[1];
                o[3*t+2][j] = q[2];
            end
        for (int t = 0; t < 2; t++) begin
            y[8*(3*t) +: 8]   = (o[3*t] >> 1) | (o[3*t] << 7);
            y[8*(3*t+1) +: 8] = o[3*t+1];
            y[8*(3*t+2) +: 8] = (o[3*t+2] << 1) | (o[3*t+2] >> 7);
        end
        return y;
    endfunction

    function automatic logic [47:0] m_rot(input logic [47:0] x);
        logic [47:0] y;
        for (int i = 0; i < 6; i++) y[8*((i+1)%6) +: 8] = x[8*i +: 8];
        return y;
    endfunction

    function automatic logic [47:0] m_rotinv(input logic [47:0] x);
        logic [47:0] y;
        for (int i = 0; i < 6; i++) y[8*i +: 8] = x[8*((i+1)%6) +: 8];
        return y;
    endfunction

    function automatic logic [95:0] m_cipher(input logic [95:0] blk, input logic [95:0] key,
                                             input logic dec);
        logic [47:0] kl [NR];
        logic [47:0] kr [NR];
        logic [47:0] krmid, tmp, l, r, f, rk;
        int c;
        kl[0] = key[95:48];
        kr[0] = key[47:0];
        krmid = '0;
        for (int i = 1; i < NR; i++) begin
            c = (i <= HK) ? i : NR - i;
            kl[i] = kr[i-1];
            kr[i] = kl[i-1] ^ m_rot(m_f(kr[i-1], 48'(c)));
            if (i == HK) begin
                krmid = kr[i];
                tmp = kl[i]; kl[i] = kr[i]; kr[i] = tmp;
            end
        end
        l = blk[95:48];
        r = blk[47:0];
        for (int i = 1; i <= NR; i++) begin
            if (i <= HK)          rk = kr[i-1];
            else if (i == HK + 1) rk = krmid;
            else                  rk = kl[i-1];
            f = m_f(r, rk);
            tmp = r;
            r = dec ? m_rotinv(l ^ f) : (m_rot(l) ^ f);
            l = tmp;
        end
        return {r, l};
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [95:0] act,
                         input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch at a negedge; returns at the negedge where done is seen.
    task automatic run_op(input logic [95:0] blk, input logic [95:0] key, input logic dec,
                          output logic [95:0] res, output int lat);
        text_in = blk;
        key_in  = key;
        decrypt = dec;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        res = text_out;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [95:0] res, res2, exp, hold;
        int lat, lat2;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!done && text_out == '0, "R1 during reset", {95'd0, done} | text_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && text_out == '0, "R1 after reset", {95'd0, done} | text_out, '0);

        // Table walk: encrypt, latency, decrypt round trip
        for (int v = 0; v < NV; v++) begin
            exp = m_cipher(VEC[v][191:96], VEC[v][95:0], 1'b0);
            run_op(VEC[v][191:96], VEC[v][95:0], 1'b0, res, lat);
            check(res == exp, "R3 R4 encrypt", res, exp);
            check(lat == NR, "R2 latency", 96'(lat), 96'(NR));
            @(negedge clk);
            check(!done, "R2 single pulse", {95'd0, done}, '0);
            run_op(res, VEC[v][95:0], 1'b1, res2, lat2);
            check(res2 == VEC[v][191:96], "R5 round trip", res2, VEC[v][191:96]);
            repeat (2) @(negedge clk);
        end

        // R5: decrypt an arbitrary block against the model
        exp = m_cipher(96'h00112233445566778899aabb, 96'h5a5a5a5a5a5a5a5a5a5a5a5a, 1'b1);
        run_op(96'h00112233445566778899aabb, 96'h5a5a5a5a5a5a5a5a5a5a5a5a, 1'b1, res, lat);
        check(res == exp, "R5 decrypt model", res, exp);

        // R6: output holds while idle with changing inputs
        hold = text_out;
        text_in = ~text_in; key_in = ~key_in; decrypt = 1'b0;
        repeat (10) @(negedge clk);
        check(text_out == hold && !done, "R6 hold idle", text_out, hold);

        // R7 + R6: restart and mode change during a run are ignored
        exp = m_cipher(VEC[2][191:96], VEC[2][95:0], 1'b0);
        text_in = VEC[2][191:96]; key_in = VEC[2][95:0]; decrypt = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(text_out == hold, "R6 hold during run", text_out, hold);
        text_in = VEC[1][191:96]; key_in = VEC[1][95:0]; decrypt = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 21;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check(text_out == exp, "R7 ignored restart", text_out, exp);
        check(lat == NR, "R7 timing kept", 96'(lat), 96'(NR));

        // R8: start in the done cycle
        res = text_out;
        exp = m_cipher(VEC[3][191:96], VEC[3][95:0], 1'b0);
        run_op(VEC[3][191:96], VEC[3][95:0], 1'b0, res2, lat);
        check(res2 == exp, "R8 chained result", res2, exp);
        check(lat == NR, "R8 chained latency", 96'(lat), 96'(NR));
        @(negedge clk);
        check(!done, "R8 done falls", {95'd0, done}, '0);

        // R1: reset mid-run
        text_in = VEC[1][191:96]; key_in = VEC[1][95:0]; decrypt = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!done && text_out == '0, "R1 reset mid-run", text_out, '0);
        rst_n = 1'b1;
        repeat (120) @(negedge clk);
        check(!done && text_out == '0, "R1 quiet after reset", text_out, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule